// File: doc/BRIEF.md
# Hybrid Zero-Compression Word Codec

This block sits between a processor and the data array of a cache that holds 32-bit words. On a write it turns a word into a 37-bit stored entry and a column-enable mask. The mask lets the array drive only the bitlines that carry information. Each word gets one of two encodings. A word that starts with a long run of equal bits keeps the run as a polarity and a length in a 6-bit header. Any other word keeps its data as it is, and one flag per byte marks the bytes that are all zero so those columns are never driven.

A read takes two sensing phases. The first phase senses a fixed set of columns: the encoding flag, the 6 header columns and the four byte flags. From these the block works out which columns the second phase needs, senses only those, and rebuilds the original word. For every access the block also reports how many columns it enabled, so the bitline activity that was saved can be counted. The array itself is outside the block. The sensed value presented on `rd_sense_i` reads zero on every column that is not enabled in that cycle.

Top module: `zcodec`

## Requirements
- R1: Stored entry layout: bit 36 is the encoding flag (1 = run encoding, 0 = byte encoding), bit 4+d holds data column d for d = 0..31, and bit b (b = 0..3) is the zero flag of byte b (data bits 8b+7..8b).
- R2: The leading run is the number L (1..32) of leading bits equal to bit 31. When L > 8 the entry has bit 36 = 1, bit 35 = bit 31 of the word, bits 34:30 = L-1, bit 4+d = word bit d for d < 32-L, and every other bit 0.
- R3: Write mask for the run encoding: bits 36..30 and bits 4..35-L are set, all other bits clear.
- R4: When L <= 8 the entry has bit 36 = 0, zero flag b set exactly when byte b is zero, and the data columns equal the word. The write mask sets bit 36, bits 3:0 and the 8 columns of each nonzero byte.
- R5: The all-zero word and the all-ones word both use the run encoding with L = 32. No low data columns are enabled, so the write mask has 7 bits set.
- R6: `wr_col_cnt_o` and `rd_col_cnt_o` equal the number of set bits in `wr_col_en_o` and `rd_col_en_o`.
- R7: A read request is taken only while `rd_ready_o` is high. Phase 1 follows in the next cycle and phase 2 in the cycle after that. `rd_valid_o` is high for exactly one cycle, the one after phase 2, and then `rd_ready_o` returns. A request raised while `rd_ready_o` is low has no effect.
- R8: During phase 1, `rd_col_en_o` sets bits 36..30 and 3..0 (11 columns) and no others.
- R9: During phase 2, `rd_col_en_o` sets only bits 4..35-L for a run entry. For a byte entry it sets the data columns below 26 that belong to bytes whose zero flag is clear.
- R10: Reading an entry returns on `rd_data_o`, together with `rd_valid_o`, exactly the word that produced the entry. Stale array contents in columns that were not enabled have no influence.
- R11: `rd_col_en_o` is zero in every cycle that is neither phase 1 nor phase 2.
- R12: After reset `rd_ready_o` = 1, `rd_valid_o` = 0, `rd_data_o` = 0 and `rd_col_en_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 32 | Word to encode |
| wr_entry_o | output | 37 | Encoded entry to store |
| wr_col_en_o | output | 37 | Columns to drive on the write |
| wr_col_cnt_o | output | 6 | Count of set bits in wr_col_en_o |
| rd_req_i | input | 1 | Start a two-phase read |
| rd_ready_o | output | 1 | Idle, a read request will be taken |
| rd_sense_i | input | 37 | Sensed entry, zero on columns not enabled |
| rd_col_en_o | output | 37 | Columns to sense in the current phase |
| rd_col_cnt_o | output | 6 | Count of set bits in rd_col_en_o |
| rd_valid_o | output | 1 | One-cycle pulse, rd_data_o holds the word |
| rd_data_o | output | 32 | Reconstructed word |

## Verification
The assertions assume that the array returns data only on the columns the block enabled in the same cycle. They also assume that the entry being read was produced by the encoder, so that a run entry always carries a length of at least 9. The bench models the array as one stored entry that is written under the write mask and read back through the read mask. It pre-loads that entry with non-zero garbage, so any reliance on a column that was not enabled shows up as a wrong word. Requests are raised only while the block is ready, except for the deliberate requests made during phase 2, which test that such requests are ignored.

// File: rtl/zc_pkg.sv
package zc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_BYTES  = WORD_W / BYTE_W;
  localparam int unsigned HDR_W    = 6;
  localparam int unsigned LEN_W    = HDR_W - 1;
  localparam int unsigned ENTRY_W  = 1 + WORD_W + N_BYTES;
  localparam int unsigned CE_POS   = ENTRY_W - 1;
  localparam int unsigned DATA_LSB = N_BYTES;
  localparam int unsigned CNT_W    = $clog2(ENTRY_W + 1);

  localparam logic [WORD_W-1:0] HDR_COLS = {{HDR_W{1'b1}}, {(WORD_W-HDR_W){1'b0}}};
  localparam logic [ENTRY_W-1:0] PH1_COLS = {1'b1, HDR_COLS, {N_BYTES{1'b1}}};

  typedef enum logic [1:0] {RD_IDLE, RD_PH1, RD_PH2, RD_DONE} rd_state_e;

  // data columns below the leading run of length len
  function automatic logic [WORD_W-1:0] low_cols(input logic [LEN_W:0] len);
    return (len >= (LEN_W+1)'(WORD_W)) ? '0 : ({WORD_W{1'b1}} >> len);
  endfunction
endpackage

// File: rtl/zc_run_count.sv
module zc_run_count #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 5
) (
  input  logic [W-1:0] word_i,
  output logic         pol_o,
  output logic [LW:0]  len_o
);
  always_comb begin
    int   n;
    logic stop;
    n    = 1;
    stop = 1'b0;
    for (int i = int'(W) - 2; i >= 0; i--) begin
      if (!stop) begin
        if (word_i[i] == word_i[W-1]) n = n + 1;
        else                          stop = 1'b1;
      end
    end
    pol_o = word_i[W-1];
    len_o = (LW+1)'(n);
  end
endmodule

// File: rtl/zc_encoder.sv
module zc_encoder
  import zc_pkg::*;
#(
  parameter int unsigned RUN_THRESH = 8
) (
  input  logic [WORD_W-1:0]  word_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic [ENTRY_W-1:0] col_en_o
);
  logic              pol;
  logic [LEN_W:0]    len;
  logic [LEN_W-1:0]  len_m1;
  logic [N_BYTES-1:0] zb;
  logic [WORD_W-1:0] byte_cols;
  logic [WORD_W-1:0] low;
  logic              long_run;

  zc_run_count #(.W(WORD_W), .LW(LEN_W)) i_run (
    .word_i(word_i),
    .pol_o (pol),
    .len_o (len)
  );

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign zb[b]                       = ~|word_i[b*BYTE_W +: BYTE_W];
    assign byte_cols[b*BYTE_W +: BYTE_W] = {BYTE_W{~zb[b]}};
  end

  assign len_m1   = LEN_W'(len - (LEN_W+1)'(1));
  assign long_run = len > (LEN_W+1)'(RUN_THRESH);
  assign low      = low_cols(len);

  always_comb begin
    entry_o  = '0;
    col_en_o = '0;
    col_en_o[CE_POS] = 1'b1;
    if (long_run) begin
      entry_o[CE_POS] = 1'b1;
      entry_o[DATA_LSB +: WORD_W]  = (word_i & low) | {pol, len_m1, {(WORD_W-HDR_W){1'b0}}};
      col_en_o[DATA_LSB +: WORD_W] = low | HDR_COLS;
    end else begin
      entry_o[DATA_LSB +: WORD_W]  = word_i;
      entry_o[N_BYTES-1:0]         = zb;
      col_en_o[DATA_LSB +: WORD_W] = byte_cols;
      col_en_o[N_BYTES-1:0]        = '1;
    end
  end
endmodule

// File: rtl/zc_popcount.sv
module zc_popcount #(
  parameter int unsigned W  = 37,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < int'(W); i++) cnt_o = cnt_o + CW'(vec_i[i]);
  end
endmodule

// File: rtl/zc_read_fsm.sv
module zc_read_fsm
  import zc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ENTRY_W-1:0] sense_i,
  output logic               ready_o,
  output logic [ENTRY_W-1:0] col_en_o,
  output logic               valid_o,
  output logic [WORD_W-1:0]  data_o
);
  rd_state_e          state_q, state_d;
  logic               ce_q;
  logic [HDR_W-1:0]   top_q;
  logic [N_BYTES-1:0] zib_q;
  logic [WORD_W-1:0]  data_q;

  logic [LEN_W:0]     len_rd;
  logic [WORD_W-1:0]  low, byte_cols, sdata, word_rec;

  assign len_rd = {1'b0, top_q[LEN_W-1:0]} + (LEN_W+1)'(1);
  assign low    = low_cols(len_rd);
  assign sdata  = sense_i[DATA_LSB +: WORD_W];

  for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
    assign byte_cols[b*BYTE_W +: BYTE_W] = {BYTE_W{~zib_q[b]}};
  end

  always_comb begin
    if (ce_q) word_rec = (sdata & low) | (top_q[HDR_W-1] ? ~low : '0);
    else      word_rec = ((sdata & ~HDR_COLS) | {top_q, {(WORD_W-HDR_W){1'b0}}}) & byte_cols;
  end

  always_comb begin
    state_d  = state_q;
    col_en_o = '0;
    unique case (state_q)
      RD_IDLE: if (req_i) state_d = RD_PH1;
      RD_PH1: begin
        col_en_o = PH1_COLS;
        state_d  = RD_PH2;
      end
      RD_PH2: begin
        col_en_o[DATA_LSB +: WORD_W] = ce_q ? low : (byte_cols & ~HDR_COLS);
        state_d = RD_DONE;
      end
      RD_DONE: state_d = RD_IDLE;
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      ce_q    <= 1'b0;
      top_q   <= '0;
      zib_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == RD_PH1) begin
        ce_q  <= sense_i[CE_POS];
        top_q <= sense_i[DATA_LSB+WORD_W-HDR_W +: HDR_W];
        zib_q <= sense_i[N_BYTES-1:0];
      end
      if (state_q == RD_PH2) data_q <= word_rec;
    end
  end

  assign ready_o = (state_q == RD_IDLE);
  assign valid_o = (state_q == RD_DONE);
  assign data_o  = data_q;
endmodule

// File: rtl/zcodec.sv
module zcodec
  import zc_pkg::*;
#(
  parameter int unsigned RUN_THRESH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic [ENTRY_W-1:0] wr_entry_o,
  output logic [ENTRY_W-1:0] wr_col_en_o,
  output logic [CNT_W-1:0]   wr_col_cnt_o,
  input  logic               rd_req_i,
  output logic               rd_ready_o,
  input  logic [ENTRY_W-1:0] rd_sense_i,
  output logic [ENTRY_W-1:0] rd_col_en_o,
  output logic [CNT_W-1:0]   rd_col_cnt_o,
  output logic               rd_valid_o,
  output logic [WORD_W-1:0]  rd_data_o
);
  zc_encoder #(.RUN_THRESH(RUN_THRESH)) i_enc (
    .word_i  (wr_data_i),
    .entry_o (wr_entry_o),
    .col_en_o(wr_col_en_o)
  );

  zc_read_fsm i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (rd_req_i),
    .sense_i (rd_sense_i),
    .ready_o (rd_ready_o),
    .col_en_o(rd_col_en_o),
    .valid_o (rd_valid_o),
    .data_o  (rd_data_o)
  );

  zc_popcount #(.W(ENTRY_W), .CW(CNT_W)) i_wr_cnt (
    .vec_i(wr_col_en_o),
    .cnt_o(wr_col_cnt_o)
  );

  zc_popcount #(.W(ENTRY_W), .CW(CNT_W)) i_rd_cnt (
    .vec_i(rd_col_en_o),
    .cnt_o(rd_col_cnt_o)
  );
endmodule

// File: rtl/zc_chk.sv
module zc_chk
  import zc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [WORD_W-1:0]  wr_data_i,
  input logic [ENTRY_W-1:0] wr_entry_o,
  input logic [ENTRY_W-1:0] wr_col_en_o,
  input logic [CNT_W-1:0]   wr_col_cnt_o,
  input logic               rd_req_i,
  input logic               rd_ready_o,
  input logic [ENTRY_W-1:0] rd_sense_i,
  input logic [ENTRY_W-1:0] rd_col_en_o,
  input logic [CNT_W-1:0]   rd_col_cnt_o,
  input logic               rd_valid_o,
  input logic [WORD_W-1:0]  rd_data_o
);
  // R3
  wr_masked_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_entry_o & ~wr_col_en_o) == '0);

  // R2
  run_len_over_thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_entry_o[CE_POS] |-> (wr_entry_o[CE_POS-2 -: LEN_W] >= LEN_W'(8)));

  // R6
  wr_cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(wr_col_cnt_o) == $countones(wr_col_en_o));

  // R6
  rd_cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rd_col_cnt_o) == $countones(rd_col_en_o));

  // R7
  req_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o && rd_req_i |=> !rd_ready_o);

  // R8
  ph1_cols_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o && rd_req_i |=> rd_col_en_o == PH1_COLS);

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o && rd_ready_o);

  // R11
  idle_no_cols_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o || rd_valid_o |-> rd_col_en_o == '0);
endmodule

bind zcodec zc_chk i_zc_chk (.*);

// File: tb/test_zcodec.sv
`timescale 1ns/1ps
module test_zcodec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [36:0] wr_entry_o, wr_col_en_o, rd_sense_i, rd_col_en_o;
  logic [5:0]  wr_col_cnt_o, rd_col_cnt_o;
  logic        rd_req_i = 1'b0;
  logic        rd_ready_o, rd_valid_o;
  logic [31:0] rd_data_o;

  logic [36:0] mem = 37'h1A5A5A5A5A;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  localparam logic [36:0] PH1 = 37'h1FC000000F;

  always #4 clk_i = ~clk_i;

  assign rd_sense_i = mem & rd_col_en_o;

  zcodec i_zcodec (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [36:0] v);
    int c = 0;
    for (int i = 0; i < 37; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic void model(input logic [31:0] w, output logic [36:0] e,
                                output logic [36:0] m, output logic [36:0] p2);
    int  n = 1;
    bit  stop = 0;
    for (int i = 30; i >= 0; i--) begin
      if (!stop && w[i] == w[31]) n++;
      else stop = 1;
    end
    e = '0; m = '0; p2 = '0;
    m[36] = 1'b1;
    if (n > 8) begin
      e[36] = 1'b1;
      e[35] = w[31];
      e[34:30] = 5'(n - 1);
      for (int j = 30; j <= 35; j++) m[j] = 1'b1;
      for (int d = 0; d < 32 - n; d++) begin
        e[4+d] = w[d]; m[4+d] = 1'b1; p2[4+d] = 1'b1;
      end
    end else begin
      m[3:0] = 4'hF;
      for (int b = 0; b < 4; b++) begin
        if (w[b*8 +: 8] == 8'h00) e[b] = 1'b1;
        else for (int j = 0; j < 8; j++) begin
          e[4+b*8+j] = w[b*8+j];
          m[4+b*8+j] = 1'b1;
          if (b*8+j < 26) p2[4+b*8+j] = 1'b1;
        end
      end
    end
  endfunction

  // driver: write then read, expected word pushed to scoreboard
  task automatic access(input logic [31:0] w, input bit poke_busy);
    logic [36:0] e, m, p2;
    model(w, e, m, p2);
    @(negedge clk_i);
    wr_data_i = w;
    #1;
    chk(wr_entry_o[36] == e[36], "R1 flag", 64'(wr_entry_o[36]), 64'(e[36]));
    chk(wr_entry_o == e, e[36] ? "R2 entry" : "R4 entry", 64'(wr_entry_o), 64'(e));
    chk(wr_col_en_o == m, e[36] ? "R3 wmask" : "R4 wmask", 64'(wr_col_en_o), 64'(m));
    chk(int'(wr_col_cnt_o) == ones(m), "R6 wcnt", 64'(wr_col_cnt_o), 64'(ones(m)));
    if (w == 32'h0 || w == 32'hFFFFFFFF)
      chk(int'(wr_col_cnt_o) == 7 && e[36], "R5 extreme", 64'(wr_col_cnt_o), 64'd7);
    @(posedge clk_i);
    mem <= (mem & ~wr_col_en_o) | (wr_entry_o & wr_col_en_o);
    @(negedge clk_i);
    chk(rd_ready_o, "R7 ready", 64'(rd_ready_o), 64'd1);
    rd_req_i = 1'b1;
    exp_q.push_back(w);
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk(rd_col_en_o == PH1, "R8 ph1", 64'(rd_col_en_o), 64'(PH1));
    chk(int'(rd_col_cnt_o) == 11, "R6 rcnt", 64'(rd_col_cnt_o), 64'd11);
    @(negedge clk_i);
    chk(rd_col_en_o == p2, "R9 ph2", 64'(rd_col_en_o), 64'(p2));
    chk(!rd_valid_o, "R7 early", 64'(rd_valid_o), 64'd0);
    if (poke_busy) rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk(rd_valid_o && rd_col_en_o == '0, "R11 done", 64'(rd_col_en_o), 64'd0);
    @(negedge clk_i);
    chk(!rd_valid_o && rd_ready_o, "R7 pulse", 64'({rd_valid_o, rd_ready_o}), 64'b01);
    chk(rd_col_en_o == '0, "R11 idle", 64'(rd_col_en_o), 64'd0);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected", 64'(rd_data_o), 64'd0);
      else begin
        logic [31:0] x;
        x = exp_q.pop_front();
        chk(rd_data_o == x, "R10 data", 64'(rd_data_o), 64'(x));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R12
    chk(rd_ready_o && !rd_valid_o && rd_data_o == 0 && rd_col_en_o == 0, "R12 reset",
        64'({rd_ready_o, rd_valid_o, rd_data_o}), 64'(33'h0) | (64'd1 << 33));
    rst_ni = 1'b1;
    access(32'h0, 1'b0);
    access(32'hFFFFFFFF, 1'b1);
    for (int pol = 0; pol < 2; pol++) begin
      for (int k = 1; k <= 32; k++) begin
        logic [31:0] w;
        w = $urandom;
        for (int i = 31; i >= 32 - k; i--) w[i] = pol[0];
        if (k < 32) w[31-k] = ~pol[0];
        access(w, k % 3 == 0);
      end
    end
    for (int zm = 0; zm < 16; zm++) begin
      logic [31:0] w;
      w = $urandom;
      for (int b = 0; b < 4; b++) begin
        if (zm[b]) w[b*8 +: 8] = 8'h00;
        else       w[b*8 +: 8] = w[b*8 +: 8] | 8'h01;
      end
      access(w, zm[0]);
      access(w ^ 32'h80000000, 1'b0);
    end
    for (int r = 0; r < 40; r++) access($urandom, r[0]);
    repeat (2) @(negedge clk_i);
    chk(exp_q.size() == 0, "R10 drained", 64'(exp_q.size()), 64'd0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule